// File: doc/BRIEF.md
# Scoreboarded Register Read and Issue Stage

This stage sits between instruction decode and the execute unit. Each decoded instruction arrives with a generation tag, an opcode, a flags/destination field and two source words. Each source word is either a register specifier or an immediate. The stage keeps a 16-entry, 64-bit register file and a per-register busy bit. When no hazard blocks it, the stage replaces register sources with their current values and hands the instruction to execute.

The busy bits stop read-after-write and write-after-write hazards. An instruction that writes a destination marks that destination busy when it issues. The commit stage clears the bit when it writes the result back. Conditional jumps, emits and stores neither test nor claim a destination.

The commit stage drives three sideband controls. It signals that a writeback is in progress, and writebacks take priority over issue. It writes a register and clears that register's busy bit. It can flush after a redirect. A flush clears the whole scoreboard and advances both the upstream and the downstream generation counters, so instructions still in flight from decode under the old tag are consumed and dropped.

Top module: `regread_issue`

## Requirements
- R1: After reset every register reads as zero, every busy bit is clear, and both generation counters are zero.
- R2: Every register specifier (source or destination) uses only its low 4 bits, which makes it a value modulo 16.
- R3: In the 8-bit flags/destination field, bits [3:0] hold the destination register, bit 4 marks source 1 as an immediate and bit 5 marks source 2 as an immediate. The field and the opcode pass to execute unchanged.
- R4: A source whose immediate bit is clear is replaced by the register value. A source whose immediate bit is set passes through unchanged.
- R5: A source whose immediate bit is clear and whose register is busy holds the instruction at the input. While held, in_ready is low and ex_valid is low.
- R6: An opcode other than 1, 2, 3 and 4 stalls while its destination is busy, and it sets its destination busy when it issues.
- R7: Opcodes 1 (jump if zero), 2 (jump if nonzero), 3 (emit) and 4 (store) ignore the destination busy bit and leave it unchanged.
- R8: An instruction issues only when in_valid and ex_ready are high and none of wb_pend, wb_we and flush is high in that cycle.
- R9: An instruction whose in_gen differs from the upstream generation is consumed (in_ready high, given ex_ready and no commit activity) and never presented to execute.
- R10: An issued instruction carries the downstream generation on ex_gen in place of its own tag.
- R11: A flush clears every busy bit. It also increments the 4-bit upstream generation and the 2-bit downstream generation, and the downstream generation wraps to zero after four increments.
- R12: A write from the commit stage updates the register and clears its busy bit at the clock edge, and the read stage sees both changes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction consumed this cycle (issued or dropped) |
| in_gen | input | 4 | Generation tag from decode |
| in_op | input | 4 | Opcode |
| in_fld | input | 8 | Flags/destination field |
| in_src1 | input | 64 | Source 1 specifier or immediate |
| in_src2 | input | 64 | Source 2 specifier or immediate |
| ex_valid | output | 1 | Instruction offered to execute |
| ex_ready | input | 1 | Execute can accept |
| ex_gen | output | 2 | Downstream generation tag |
| ex_op | output | 4 | Opcode to execute |
| ex_fld | output | 8 | Flags/destination field to execute |
| ex_a | output | 64 | Resolved operand 1 |
| ex_b | output | 64 | Resolved operand 2 |
| wb_pend | input | 1 | Commit stage handling a writeback this cycle |
| wb_we | input | 1 | Register write and busy clear |
| wb_idx | input | 4 | Register index for the write |
| wb_data | input | 64 | Write data |
| flush | input | 1 | Clear scoreboard and advance generations |

## Verification
On every cycle the assertions check four things: nothing is offered to execute while commit activity blocks the stage, a stale tag never reaches execute, a flush clears the scoreboard and steps both counters, and busy bits are set and cleared after issues and writes. Only the bench's scenarios can show the operand values delivered with each instruction. The same goes for modulo-16 specifier reduction, immediate pass-through, stalls that end once a write clears the busy bit, and the downstream tag wrapping after four flushes. These come out in the order-checked stream of issued items.

// File: rtl/regread_issue.sv
module regread_issue #(
  parameter int NREG     = 16,
  parameter int XLEN     = 64,
  parameter int OPW      = 4,
  parameter int FW       = 8,
  parameter int UGW      = 4,
  parameter int DGW      = 2,
  parameter int IMM1_BIT = 4,
  parameter int IMM2_BIT = 5,
  parameter logic [OPW-1:0] OP_JZ    = 1,
  parameter logic [OPW-1:0] OP_JNZ   = 2,
  parameter logic [OPW-1:0] OP_EMIT  = 3,
  parameter logic [OPW-1:0] OP_STORE = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [UGW-1:0]  in_gen,
  input  logic [OPW-1:0]  in_op,
  input  logic [FW-1:0]   in_fld,
  input  logic [XLEN-1:0] in_src1,
  input  logic [XLEN-1:0] in_src2,
  output logic            ex_valid,
  input  logic            ex_ready,
  output logic [DGW-1:0]  ex_gen,
  output logic [OPW-1:0]  ex_op,
  output logic [FW-1:0]   ex_fld,
  output logic [XLEN-1:0] ex_a,
  output logic [XLEN-1:0] ex_b,
  input  logic            wb_pend,
  input  logic            wb_we,
  input  logic [IW-1:0]   wb_idx,
  input  logic [XLEN-1:0] wb_data,
  input  logic            flush
);

  logic [XLEN-1:0] regs [NREG];
  logic [NREG-1:0] busy, busy_nxt;
  logic [UGW-1:0]  gen_up;
  logic [DGW-1:0]  gen_dn;

  logic [IW-1:0] s1_idx, s2_idx, d_idx;
  logic imm1, imm2, claims, gen_ok, hazard, blocked, issue;

  assign s1_idx  = in_src1[IW-1:0];
  assign s2_idx  = in_src2[IW-1:0];
  assign d_idx   = in_fld[IW-1:0];
  assign imm1    = in_fld[IMM1_BIT];
  assign imm2    = in_fld[IMM2_BIT];
  assign claims  = !(in_op == OP_JZ || in_op == OP_JNZ || in_op == OP_EMIT || in_op == OP_STORE);
  assign gen_ok  = (in_gen == gen_up);
  assign blocked = wb_pend | wb_we | flush;
  assign hazard  = (!imm1 && busy[s1_idx]) | (!imm2 && busy[s2_idx]) | (claims && busy[d_idx]);

  assign ex_valid = in_valid & gen_ok & !hazard & !blocked;
  assign in_ready = ex_ready & !blocked & (!gen_ok | !hazard);
  assign issue    = ex_valid & ex_ready;

  assign ex_gen = gen_dn;
  assign ex_op  = in_op;
  assign ex_fld = in_fld;
  assign ex_a   = imm1 ? in_src1 : regs[s1_idx];
  assign ex_b   = imm2 ? in_src2 : regs[s2_idx];

  always_comb begin
    busy_nxt = busy;
    if (wb_we) busy_nxt[wb_idx] = 1'b0;
    if (issue && claims) busy_nxt[d_idx] = 1'b1;
    if (flush) busy_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      busy   <= '0;
      gen_up <= '0;
      gen_dn <= '0;
    end else begin
      if (wb_we) regs[wb_idx] <= wb_data;
      busy <= busy_nxt;
      if (flush) begin
        gen_up <= gen_up + 1'b1;
        gen_dn <= gen_dn + 1'b1;
      end
    end
  end

endmodule

// File: rtl/regread_issue_chk.sv
module regread_issue_chk #(
  parameter int NREG = 16,
  parameter int OPW  = 4,
  parameter int FW   = 8,
  parameter int UGW  = 4,
  parameter int DGW  = 2,
  parameter logic [OPW-1:0] OP_JZ    = 1,
  parameter logic [OPW-1:0] OP_JNZ   = 2,
  parameter logic [OPW-1:0] OP_EMIT  = 3,
  parameter logic [OPW-1:0] OP_STORE = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [UGW-1:0]  in_gen,
  input logic [OPW-1:0]  in_op,
  input logic [FW-1:0]   in_fld,
  input logic            ex_valid,
  input logic            ex_ready,
  input logic            wb_pend,
  input logic            wb_we,
  input logic [IW-1:0]   wb_idx,
  input logic            flush,
  input logic [NREG-1:0] busy,
  input logic [UGW-1:0]  gen_up,
  input logic [DGW-1:0]  gen_dn
);

  logic nodst;
  assign nodst = (in_op == OP_JZ) || (in_op == OP_JNZ) || (in_op == OP_EMIT) || (in_op == OP_STORE);

  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> !(wb_pend || wb_we || flush));

  assert_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready) |-> in_ready);

  assert_stale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_gen != gen_up) |-> !ex_valid);

  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy == '0));

  assert_flush_gen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (gen_up == UGW'($past(gen_up) + 1'b1)) && (gen_dn == DGW'($past(gen_dn) + 1'b1)));

  assert_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && !nodst) |=> busy[$past(in_fld[IW-1:0])]);

  assert_noclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && nodst) |=> (busy == $past(busy)));

  assert_wb_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> !busy[$past(wb_idx)]);

endmodule

bind regread_issue regread_issue_chk #(
  .NREG(NREG), .OPW(OPW), .FW(FW), .UGW(UGW), .DGW(DGW),
  .OP_JZ(OP_JZ), .OP_JNZ(OP_JNZ), .OP_EMIT(OP_EMIT), .OP_STORE(OP_STORE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_gen(in_gen), .in_op(in_op), .in_fld(in_fld), .ex_valid(ex_valid),
  .ex_ready(ex_ready), .wb_pend(wb_pend), .wb_we(wb_we), .wb_idx(wb_idx),
  .flush(flush), .busy(busy), .gen_up(gen_up), .gen_dn(gen_dn)
);

// File: tb/tb_regread_issue.sv
`timescale 1ns/1ps
module tb_regread_issue;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 0, ex_ready = 0, wb_pend = 0, wb_we = 0, flush = 0;
  logic        in_ready, ex_valid;
  logic [3:0]  in_gen = 0, in_op = 0, wb_idx = 0;
  logic [7:0]  in_fld = 0;
  logic [63:0] in_src1 = 0, in_src2 = 0, wb_data = 0;
  logic [1:0]  ex_gen;
  logic [3:0]  ex_op;
  logic [7:0]  ex_fld;
  logic [63:0] ex_a, ex_b;

  regread_issue dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_gen(in_gen), .in_op(in_op), .in_fld(in_fld), .in_src1(in_src1),
    .in_src2(in_src2), .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_gen(ex_gen),
    .ex_op(ex_op), .ex_fld(ex_fld), .ex_a(ex_a), .ex_b(ex_b), .wb_pend(wb_pend),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data), .flush(flush)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  fld;
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  gen;
  } item_t;

  item_t       expq[$];
  int          checks = 0, errors = 0;
  logic [63:0] mregs [16];
  logic [15:0] mbusy = '0;
  logic [3:0]  mup = '0;
  logic [1:0]  mdn = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each accepted issue against the queue
  always begin
    @(negedge clk);
    #2;
    if (rst_n && ex_valid && ex_ready) begin
      if (expq.size() == 0) begin
        chk("R8", "unexpected issue", 1, 0);
      end else begin
        item_t e;
        e = expq.pop_front();
        chk("R3", "ex_op", ex_op, e.op);
        chk("R3", "ex_fld", ex_fld, e.fld);
        chk("R4", "ex_a", ex_a, e.a);
        chk("R4", "ex_b", ex_b, e.b);
        chk("R10", "ex_gen", ex_gen, e.gen);
      end
    end
  end

  task automatic cyc(logic iv, logic [3:0] g, logic [3:0] op, logic [7:0] fld,
                     logic [63:0] s1, logic [63:0] s2, logic er,
                     logic pd, logic we, logic [3:0] idx, logic [63:0] dat, logic fl);
    logic claims, haz, blk, gm, eev, erdy;
    string tag;
    @(negedge clk);
    in_valid = iv; in_gen = g; in_op = op; in_fld = fld; in_src1 = s1; in_src2 = s2;
    ex_ready = er; wb_pend = pd; wb_we = we; wb_idx = idx; wb_data = dat; flush = fl;
    claims = !(op inside {4'd1, 4'd2, 4'd3, 4'd4});
    haz  = (!fld[4] && mbusy[s1[3:0]]) || (!fld[5] && mbusy[s2[3:0]]) || (claims && mbusy[fld[3:0]]);
    blk  = pd || we || fl;
    gm   = (g == mup);
    eev  = iv && gm && !haz && !blk;
    erdy = er && !blk && (!gm || !haz);
    if (blk) tag = "R8";
    else if (!gm) tag = "R9";
    else if ((!fld[4] && mbusy[s1[3:0]]) || (!fld[5] && mbusy[s2[3:0]])) tag = "R5";
    else if (haz) tag = "R6";
    else tag = "R8";
    if (eev && er)
      expq.push_back('{op: op, fld: fld,
                       a: fld[4] ? s1 : mregs[s1[3:0]],
                       b: fld[5] ? s2 : mregs[s2[3:0]], gen: mdn});
    #1;
    chk(tag, "ex_valid", ex_valid, eev);
    if (iv) chk(tag, "in_ready", in_ready, erdy);
    @(posedge clk);
    if (we) begin mregs[idx] = dat; mbusy[idx] = 1'b0; end
    if (eev && er && claims) mbusy[fld[3:0]] = 1'b1;
    if (fl) begin mbusy = '0; mup = mup + 1'b1; mdn = mdn + 1'b1; end
  endtask

  task automatic ins(logic [3:0] g, logic [3:0] op, logic [7:0] fld, logic [63:0] s1, logic [63:0] s2);
    cyc(1, g, op, fld, s1, s2, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [3:0] idx, logic [63:0] dat);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, idx, dat, 0);
  endtask

  task automatic do_flush();
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ex_valid at reset", ex_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: registers read as zero, nothing busy
    ins(0, 0, 8'h01, 64'd2, 64'd3);
    // R12: write clears busy and updates value
    wr(1, 64'hAAAA_5555_0000_1111);
    wr(2, 64'h22);
    wr(3, 64'h33);
    // R2: specifier 0x12 selects r2; R3/R4: source 2 immediate
    ins(0, 0, 8'h24, 64'h12, 64'hDEAD_BEEF);
    // R5: source r4 busy
    ins(0, 0, 8'h05, 64'd4, 64'd1);
    ins(0, 0, 8'h05, 64'hF4, 64'd1);
    // R6: destination r4 busy, sources immediate
    ins(0, 0, 8'h34, 64'd7, 64'd8);
    // R7: store and jumps ignore busy destination r4 and do not claim
    ins(0, 4, 8'h34, 64'h100, 64'h200);
    ins(0, 1, 8'h14, 64'd4 + 64'd0, 64'd1);
    ins(0, 2, 8'h34, 64'h5, 64'h6);
    ins(0, 3, 8'h36, 64'd9, 64'd9);
    // R7: r6 still free after emit
    ins(0, 0, 8'h36, 64'd1, 64'd2);
    // R8: commit activity blocks issue
    cyc(1, 0, 0, 8'h37, 64'd1, 64'd1, 1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 8'h37, 64'd1, 64'd1, 1, 1, 1, 4, 64'h44, 0);
    // R12: r4 now free with new value
    ins(0, 0, 8'h27, 64'd4, 64'h77);
    // R8: execute not ready
    cyc(1, 0, 0, 8'h38, 64'd1, 64'd1, 0, 0, 0, 0, 0, 0);
    // R9: stale generation dropped
    ins(3, 0, 8'h09, 64'd1, 64'd2);
    // R11: flush clears busy and bumps generations
    do_flush();
    ins(0, 0, 8'h0A, 64'd1, 64'd2);
    ins(1, 0, 8'h06, 64'd4, 64'd7);
    ins(1, 0, 8'h0B, 64'd6, 64'd2);
    // R6: WAW on newly claimed r6
    ins(1, 0, 8'h36, 64'd0, 64'd0);
    // R11/R10: downstream tag wraps after four flushes
    do_flush();
    do_flush();
    do_flush();
    ins(4, 0, 8'h16, 64'h55, 64'd1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R8", "pending expected items", expq.size(), 0);
    report();
  end

endmodule